// File: doc/BRIEF.md
# Power-of-Two Region Fitter with Subregion Trimming

This block takes an arbitrary byte span, given as a start address and a length, and tries to express it as a single protection region. The region must be a naturally sized power of two. It may carry an 8-bit mask in which each set bit disables one eighth of the region. The fitter first clears the address bits below the span length to find an aligned base. It then rounds the covered extent up to the next power of two. Finally it removes the unwanted eighths at the low end and at the high end by setting disable bits from each side of the mask.

A caller raises `start` for one cycle while `ready` is high. Three cycles later a one-cycle `done` pulse comes with the result: the aligned base, the region size as a base-2 exponent, the disable mask and a success flag. A span that cannot be expressed exactly is rejected. This happens when its gaps fall off the eighth boundaries, when the eighths would be smaller than the configured minimum, when the region would exceed the address space, or when the length is zero. Splitting a long span over several regions is left to the caller.

Top module: `pow2_region_fit`

## Requirements
- R1: After reset `ready` is 1 and `done`, `fit_ok`, `rgn_base`, `rgn_order` and `sub_dis` are 0. A `start` seen while `ready` is 1 begins a computation and drives `ready` to 0 until the result cycle. A `start` seen while `ready` is 0 is ignored and does not change the pending result.
- R2: `done` is high for exactly one cycle. It rises after the fourth rising clock edge, counting the edge that samples `start`. `ready` is 1 again in that same cycle.
- R3: `rgn_base` is the input address with every bit below the input length cleared (address AND NOT (length-1)). `rgn_order` is the exponent of the smallest power of two that is at least (address + length - `rgn_base`).
- R4: The leading gap (address minus `rgn_base`) divided by the eighth size (2^(`rgn_order`-3)) sets that many `sub_dis` bits, starting at bit 0 and counting upward.
- R5: The trailing gap (2^`rgn_order` minus the covered extent) divided by the eighth size sets that many `sub_dis` bits, starting at bit 7 and counting downward.
- R6: The fit fails if the leading or the trailing gap is not a whole multiple of the eighth size. It also fails if a gap exists while the region is smaller than 8 bytes.
- R7: If any disable bit would be needed, the fit fails when the eighth size is below 2^MIN_SUB_LOG2 bytes or when the leading and trailing slot counts together exceed 8. With no gap at either end the fit succeeds with `sub_dis` = 0 at any region size.
- R8: A length of zero reports failure. On every failure `rgn_base`, `rgn_order` and `sub_dis` are 0.
- R9: The fit fails when the region would exceed 2^32 bytes. A region of exactly 2^32 bytes (`rgn_order` = 32) is allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a fit when `ready` is high |
| span_addr | input | 32 | Start address of the span |
| span_len | input | 32 | Length of the span in bytes |
| ready | output | 1 | Idle and able to accept `start` |
| done | output | 1 | One-cycle result strobe |
| fit_ok | output | 1 | Span expressed exactly by the result |
| rgn_base | output | 32 | Aligned region base |
| rgn_order | output | 6 | Region size exponent (size = 2^rgn_order) |
| sub_dis | output | 8 | Subregion disable mask, bit i covers eighth i |

## Verification
Several spans are fed to the block. An already aligned power-of-two span checks that the base and exponent come out plain with an empty mask. A span that ends short of the rounded size isolates the top-down trailing bits. A span that starts inside an eighth and runs past a boundary exercises both ends of the mask at once. Rejections are separated by cause, using small variants of an accepted span: an offset off the eighth grid, eighths below the minimum size, a gap in a region under 8 bytes, zero length, and an extent beyond 4 GiB. Tiny gap-free spans, a full 2^32 region and a `start` issued while busy cover the edges of the size range and the handshake.

// File: rtl/rf_pkg.sv
package rf_pkg;
    localparam int NSUB   = 8;
    localparam int SUB_SH = 3;
    localparam int SLW    = $clog2(NSUB) + 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ALIGN = 2'd1,
        ST_ROUND = 2'd2,
        ST_TRIM  = 2'd3
    } rf_state_e;
endpackage

// File: rtl/rf_msb_find.sv
module rf_msb_find #(
    parameter int W = 33,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx
);
    // highest set bit wins; zero input yields index 0
    always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/rf_mask_build.sv
module rf_mask_build #(
    parameter int NSUB = 8,
    parameter int SLW  = 4
) (
    input  logic [SLW-1:0]  lo_cnt,
    input  logic [SLW-1:0]  hi_cnt,
    output logic [NSUB-1:0] mask
);
    localparam logic [SLW-1:0] TOP = SLW'(NSUB);

    generate
        for (genvar g = 0; g < NSUB; g++) begin : g_bit
            assign mask[g] = (SLW'(g) < lo_cnt) || (SLW'(g) >= TOP - hi_cnt);
        end
    endgenerate

    // R4, R5: a mask within budget carries exactly the requested slot count
    always_comb begin
        if ({1'b0, lo_cnt} + {1'b0, hi_cnt} <= (SLW+1)'(NSUB)) begin
            a_r4_mask_count: assert ($countones(mask) == int'(lo_cnt) + int'(hi_cnt))
                else $error("mask population differs from slot count");
        end
    end
endmodule

// File: rtl/rf_gap_eval.sv
module rf_gap_eval
    import rf_pkg::*;
#(
    parameter int AW           = 32,
    parameter int OW           = 6,
    parameter int MIN_SUB_LOG2 = 5,
    localparam int SW = AW + 1,
    localparam int PW = AW + 2
) (
    input  logic [AW-1:0]   addr,
    input  logic [AW-1:0]   abase,
    input  logic [SW-1:0]   extent,
    input  logic [OW-1:0]   ord,
    output logic            fit,
    output logic [NSUB-1:0] mask
);
    logic [PW-1:0]  p2;
    logic [PW-1:0]  lead;
    logic [PW-1:0]  trail;
    logic [PW-1:0]  low_mask;
    logic [OW-1:0]  sub_ord;
    logic           tiny;
    logic           any_gap;
    logic           off_grid;
    logic [SLW-1:0] lo_cnt;
    logic [SLW-1:0] hi_cnt;

    always_comb begin
        p2      = PW'(1) << ord;
        lead    = PW'(addr - abase);
        trail   = p2 - PW'(extent);
        tiny    = (ord < OW'(SUB_SH));
        sub_ord = tiny ? '0 : ord - OW'(SUB_SH);
        low_mask = (PW'(1) << sub_ord) - PW'(1);
        off_grid = (|(lead & low_mask)) || (|(trail & low_mask));
        lo_cnt  = SLW'(lead >> sub_ord);
        hi_cnt  = SLW'(trail >> sub_ord);
        any_gap = (|lead) || (|trail);

        if (!any_gap)
            fit = 1'b1;
        else if (tiny || off_grid)
            fit = 1'b0;
        else if (sub_ord < OW'(MIN_SUB_LOG2))
            fit = 1'b0;
        else if ({1'b0, lo_cnt} + {1'b0, hi_cnt} > (SLW+1)'(NSUB))
            fit = 1'b0;
        else
            fit = 1'b1;
    end

    rf_mask_build #(.NSUB(NSUB), .SLW(SLW)) u_mask (
        .lo_cnt (lo_cnt),
        .hi_cnt (hi_cnt),
        .mask   (mask)
    );

    // R7: a gap-free span never needs a disable bit
    always_comb begin
        if (!any_gap) begin
            a_r7_no_gap_clear: assert (mask == '0)
                else $error("disable bits without a gap");
        end
    end
endmodule

// File: rtl/pow2_region_fit.sv
module pow2_region_fit
    import rf_pkg::*;
#(
    parameter int AW           = 32,
    parameter int MIN_SUB_LOG2 = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AW-1:0]    span_addr,
    input  logic [AW-1:0]    span_len,
    output logic             ready,
    output logic             done,
    output logic             fit_ok,
    output logic [AW-1:0]    rgn_base,
    output logic [5:0]       rgn_order,
    output logic [NSUB-1:0]  sub_dis
);
    localparam int SW = AW + 1;
    localparam int OW = 6;
    localparam int IW = $clog2(SW);

    typedef struct packed {
        rf_state_e       st;
        logic [AW-1:0]   addr;
        logic [AW-1:0]   len;
        logic [AW-1:0]   abase;
        logic [SW-1:0]   extent;
        logic [OW-1:0]   ord;
        logic            done;
        logic            ok;
        logic [AW-1:0]   r_base;
        logic [OW-1:0]   r_ord;
        logic [NSUB-1:0] r_mask;
    } regs_t;

    regs_t r_d, r_q;

    logic [IW-1:0]   msb_idx;
    logic            is_pow2;
    logic            gap_fit;
    logic [NSUB-1:0] gap_mask;
    logic            good;

    rf_msb_find #(.W(SW)) u_msb (
        .vec (r_q.extent),
        .idx (msb_idx)
    );

    rf_gap_eval #(.AW(AW), .OW(OW), .MIN_SUB_LOG2(MIN_SUB_LOG2)) u_gap (
        .addr   (r_q.addr),
        .abase  (r_q.abase),
        .extent (r_q.extent),
        .ord    (r_q.ord),
        .fit    (gap_fit),
        .mask   (gap_mask)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        is_pow2  = ((r_q.extent & (r_q.extent - SW'(1))) == '0);
        good     = gap_fit && (r_q.len != '0) && (r_q.ord <= OW'(AW));

        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.addr = span_addr;
                    r_d.len  = span_len;
                    r_d.st   = ST_ALIGN;
                end
            end
            ST_ALIGN: begin
                r_d.abase  = r_q.addr & ~(r_q.len - AW'(1));
                r_d.extent = {1'b0, r_q.addr} + {1'b0, r_q.len}
                           - {1'b0, r_q.addr & ~(r_q.len - AW'(1))};
                r_d.st     = ST_ROUND;
            end
            ST_ROUND: begin
                r_d.ord = OW'(msb_idx) + (is_pow2 ? OW'(0) : OW'(1));
                r_d.st  = ST_TRIM;
            end
            ST_TRIM: begin
                r_d.done   = 1'b1;
                r_d.ok     = good;
                r_d.r_base = good ? r_q.abase : '0;
                r_d.r_ord  = good ? r_q.ord   : '0;
                r_d.r_mask = good ? gap_mask  : '0;
                r_d.st     = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ready     = (r_q.st == ST_IDLE);
    assign done      = r_q.done;
    assign fit_ok    = r_q.ok;
    assign rgn_base  = r_q.r_base;
    assign rgn_order = r_q.r_ord;
    assign sub_dis   = r_q.r_mask;

    a_r1_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ready) |=> !ready);

    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r2_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(!ready));

    a_r8_fail_zeros: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fit_ok) |-> (rgn_base == '0 && rgn_order == '0 && sub_dis == '0));

    a_r9_order_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fit_ok) |-> (rgn_order <= 6'(AW)));
endmodule

// File: tb/sim_pow2_region_fit.sv
module sim_pow2_region_fit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] span_addr = '0;
    logic [31:0] span_len = '0;
    logic        ready, done, fit_ok;
    logic [31:0] rgn_base;
    logic [5:0]  rgn_order;
    logic [7:0]  sub_dis;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pow2_region_fit #(.AW(32), .MIN_SUB_LOG2(5)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .span_addr(span_addr), .span_len(span_len),
        .ready(ready), .done(done), .fit_ok(fit_ok),
        .rgn_base(rgn_base), .rgn_order(rgn_order), .sub_dis(sub_dis)
    );

    task automatic chk(input bit cond, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!cond) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // issue one fit, return cycles until done (sampled at negedges)
    task automatic run_fit(input logic [31:0] a, input logic [31:0] l, output int lat);
        @(negedge clk);
        span_addr = a; span_len = l; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic expect_fit(input string req, input logic [31:0] a, input logic [31:0] l,
                              input bit ok, input logic [31:0] b, input logic [5:0] o,
                              input logic [7:0] m);
        int lat;
        run_fit(a, l, lat);
        chk(lat == 4, "R2", "latency", 64'(lat), 64'd4);
        chk(fit_ok == ok, req, "fit_ok", 64'(fit_ok), 64'(ok));
        chk(rgn_base == b, req, "rgn_base", 64'(rgn_base), 64'(b));
        chk(rgn_order == o, req, "rgn_order", 64'(rgn_order), 64'(o));
        chk(sub_dis == m, req, "sub_dis", 64'(sub_dis), 64'(m));
    endtask

    task automatic t_reset;
        chk(ready == 1'b1, "R1", "reset ready", 64'(ready), 64'd1);
        chk(done == 1'b0, "R1", "reset done", 64'(done), 64'd0);
        chk({fit_ok, rgn_base, rgn_order, sub_dis} == '0, "R1", "reset outputs",
            64'({fit_ok, rgn_base, rgn_order, sub_dis}), 64'd0);
    endtask

    task automatic t_aligned;   // R3: plain aligned span
        expect_fit("R3", 32'h0000_1000, 32'h0000_1000, 1'b1, 32'h0000_1000, 6'd12, 8'h00);
        chk(ready == 1'b1, "R2", "ready in done cycle", 64'(ready), 64'd1);
        @(negedge clk);
        chk(done == 1'b0, "R2", "done one cycle", 64'(done), 64'd0);
    endtask

    task automatic t_trailing;  // R5: two top eighths disabled
        expect_fit("R5", 32'h0000_0000, 32'h0000_3000, 1'b1, 32'h0, 6'd14, 8'hC0);
    endtask

    task automatic t_both_ends; // R4 and R5: bits 0..2 and bit 7
        expect_fit("R4", 32'h0000_0C00, 32'h0000_1000, 1'b1, 32'h0, 6'd13, 8'h87);
    endtask

    task automatic t_off_grid;  // R6
        expect_fit("R6", 32'h0000_0C10, 32'h0000_1000, 1'b0, 32'h0, 6'd0, 8'h00);
        expect_fit("R6", 32'h0000_0001, 32'h0000_0002, 1'b0, 32'h0, 6'd0, 8'h00);
    endtask

    task automatic t_min_sub;   // R7: eighths of 4 bytes are below 32
        expect_fit("R7", 32'h0000_000C, 32'h0000_0010, 1'b0, 32'h0, 6'd0, 8'h00);
    endtask

    task automatic t_no_gap_small; // R7: gap-free tiny regions succeed
        expect_fit("R7", 32'h0000_0004, 32'h0000_0004, 1'b1, 32'h4, 6'd2, 8'h00);
        expect_fit("R7", 32'h0000_0040, 32'h0000_0040, 1'b1, 32'h40, 6'd6, 8'h00);
    endtask

    task automatic t_zero_len;  // R8
        expect_fit("R8", 32'h0000_1234, 32'h0, 1'b0, 32'h0, 6'd0, 8'h00);
    endtask

    task automatic t_size_limits; // R9
        expect_fit("R9", 32'h0000_0000, 32'hE000_0000, 1'b1, 32'h0, 6'd32, 8'h80);
        expect_fit("R9", 32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 32'h0, 6'd0, 8'h00);
    endtask

    task automatic t_busy_start; // R1: start while busy is ignored
        int lat;
        @(negedge clk);
        span_addr = 32'h0000_1000; span_len = 32'h0000_1000; start = 1'b1;
        @(negedge clk);
        chk(ready == 1'b0, "R1", "ready low when busy", 64'(ready), 64'd0);
        span_addr = 32'h0000_0C10; span_len = 32'h0000_0010;
        @(negedge clk);
        start = 1'b0;
        lat = 2;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == 4, "R1", "latency with busy start", 64'(lat), 64'd4);
        chk(fit_ok == 1'b1 && rgn_base == 32'h1000 && rgn_order == 6'd12, "R1",
            "first request kept", 64'({fit_ok, rgn_base, rgn_order}),
            64'({1'b1, 32'h1000, 6'd12}));
        @(negedge clk);
        chk(done == 1'b0 && ready == 1'b1, "R1", "no second result",
            64'({done, ready}), 64'b01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_aligned();
        t_trailing();
        t_both_ends();
        t_off_grid();
        t_min_sub();
        t_no_gap_small();
        t_zero_len();
        t_size_limits();
        t_busy_start();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule